// File: doc/BRIEF.md
# Three-Lane Transform Result Output Buffer

This block sits behind a transform engine that emits each finished block as three parallel complex lanes. Every engine cycle carries one complex sample per lane. For a block of N samples, lane 0 carries the first third, lane 1 the middle third and lane 2 the final third. The engine announces a new block by raising a start flag on its first beat. On that same beat it gives the number of beats per lane and the block's scale exponent. The block marks the first and last beats of each packet. It keeps the exponent fixed for the whole packet and presents the result on a valid/ready source stream.

A compile-time switch selects between two builds. In the buffered build, beats go into a FIFO whose depth and address width are parameters. Each entry holds one beat of all three lanes together with its packet markers and exponent. The downstream ready input works with zero ready latency. Results arrive in bursts, so if the FIFO is full and nothing leaves, the incoming beat is discarded and a sticky flag records the event. In the bypass build, the beat and its markers appear on the source port in the same cycle, and the ready input has no effect.

Top module: `tri_lane_outbuf`

## Requirements
- R1: While reset is asserted and just after it, `out_valid` and `ovf_err` are 0.
- R2: Beats leave in the order they were accepted. Lane k sits at bits [k*DW +: DW] of `out_re`/`out_im`, with lane 0 holding the first third of the block, and each lane's value is unchanged from input to output.
- R3: `out_sop` is 1 exactly on the beat that arrived with `in_start`. `out_eop` is 1 exactly on the `in_beats`-th accepted beat of that block, counting only cycles with `in_valid`. A one-beat block carries both markers.
- R4: `in_exp` is taken only on a start beat. Every beat of the packet presents that value on `out_exp`, whatever `in_exp` holds on later beats and whatever later blocks carry.
- R5: In the buffered build, a beat is removed only in a cycle with `out_valid` and `out_ready` both 1. While `out_valid` is 1 and `out_ready` is 0, all source outputs hold their values into the next cycle.
- R6: In the buffered build, `out_valid` is 1 in every cycle in which the FIFO holds at least one beat.
- R7: An input beat that arrives while the FIFO is full and no beat leaves is dropped, and the stored beats are left intact. `ovf_err` then becomes 1 and stays 1 until reset.
- R8: An input beat that arrives while the FIFO is full, in a cycle in which a beat leaves, is accepted and does not set `ovf_err`.
- R9: In the bypass build, `out_valid` equals `in_valid` and the data, markers and exponent appear in the same cycle. `out_ready` has no effect and `ovf_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Engine beat present |
| in_start | input | 1 | Beat is the first of a block |
| in_beats | input | BW | Beats per lane of the block, sampled with in_start (at least 1) |
| in_exp | input | EW | Block exponent, sampled with in_start |
| in_re | input | 3*DW | Real parts, lane k at [k*DW +: DW] |
| in_im | input | 3*DW | Imaginary parts, same lane layout |
| out_ready | input | 1 | Downstream ready, zero latency (buffered build only) |
| out_valid | output | 1 | Source beat present |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |
| out_exp | output | EW | Exponent of the current packet |
| out_re | output | 3*DW | Real parts of the three lanes |
| out_im | output | 3*DW | Imaginary parts of the three lanes |
| ovf_err | output | 1 | Sticky flag, set when a beat is dropped |

## Verification
Blocks of one, several and more-than-depth beats are sent under four ready patterns: always high, alternating, a three-cycle pattern and held low. These separate correct ordering and marker placement from errors that only show when the FIFO stalls or wraps. Several blocks are parked in the FIFO with ready low before draining, and `in_exp` carries garbage on non-start beats. Together these show whether each packet keeps its own exponent. A beat with gaps tests marker counting across idle cycles. Two cases pin down the full-FIFO boundary: filling it and then writing while a beat leaves, and writing past full with ready low. The first must leave the flag clear; the second must set it and lose only the excess beats. A bypass instance sharing the same stimulus is checked every cycle for same-cycle pass-through.

// File: rtl/tob_pkg.sv
package tob_pkg;
    localparam int LANES = 3;
endpackage

// File: rtl/tob_marker.sv
module tob_marker #(
    parameter int EW = 8,
    parameter int BW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [BW-1:0] in_beats,
    input  logic [EW-1:0] in_exp,
    output logic          m_sop,
    output logic          m_eop,
    output logic [EW-1:0] m_exp
);
    typedef struct packed {
        logic [BW-1:0] rem;
        logic [EW-1:0] exp;
    } mk_t;

    mk_t s_d, s_q;
    logic [BW-1:0] cur_rem;
    logic [EW-1:0] cur_exp;

    always_comb begin
        s_d     = s_q;
        cur_rem = in_start ? in_beats : s_q.rem;
        cur_exp = in_start ? in_exp : s_q.exp;
        m_sop   = in_valid && in_start;
        m_eop   = in_valid && (cur_rem == BW'(1));
        m_exp   = cur_exp;
        if (in_valid) begin
            s_d.exp = cur_exp;
            s_d.rem = (cur_rem != '0) ? cur_rem - BW'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: without a new start, the presented exponent does not move
    assert_exp_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_start && $past(!in_start || in_valid)) |-> m_exp == $past(m_exp));
endmodule

// File: rtl/tob_fifo.sv
module tob_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         rd_ready,
    output logic         rd_valid,
    output logic [W-1:0] dout,
    output logic         err
);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
        logic          err;
    } fq_t;

    fq_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic pop, full, acc, drop;

    initial assert (2**AW >= DEPTH && DEPTH >= 4);

    always_comb begin
        s_d      = s_q;
        rd_valid = (s_q.cnt != '0);
        full     = (s_q.cnt == FULL_CNT);
        pop      = rd_valid && rd_ready;
        acc      = push && (!full || pop);
        drop     = push && full && !pop;
        if (acc) s_d.wp = (s_q.wp == LAST_IDX) ? '0 : s_q.wp + AW'(1);
        if (pop) s_d.rp = (s_q.rp == LAST_IDX) ? '0 : s_q.rp + AW'(1);
        if (acc && !pop)      s_d.cnt = s_q.cnt + (AW+1)'(1);
        else if (pop && !acc) s_d.cnt = s_q.cnt - (AW+1)'(1);
        if (drop) s_d.err = 1'b1;
        dout = mem[s_q.rp];
        err  = s_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (acc) mem[s_q.wp] <= din;
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT);
    assert_drop_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> s_q.cnt == $past(s_q.cnt) && s_q.rp == $past(s_q.rp));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_full_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && rd_ready) |=> err == $past(err));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid && dout == $past(dout));
    assert_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rd_valid);
endmodule

// File: rtl/tri_lane_outbuf.sv
module tri_lane_outbuf #(
    parameter int DW        = 16,
    parameter int EW        = 8,
    parameter int DEPTH     = 16,
    parameter int AW        = 4,
    parameter int MAX_BEATS = 1080,
    parameter bit USE_BUF   = 1'b1,
    localparam int BW       = $clog2(MAX_BEATS + 1),
    localparam int LW       = tob_pkg::LANES * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [BW-1:0] in_beats,
    input  logic [EW-1:0] in_exp,
    input  logic [LW-1:0] in_re,
    input  logic [LW-1:0] in_im,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic [EW-1:0] out_exp,
    output logic [LW-1:0] out_re,
    output logic [LW-1:0] out_im,
    output logic          ovf_err
);
    localparam int EWID = 2 + EW + 2 * LW;

    logic          m_sop, m_eop;
    logic [EW-1:0] m_exp;

    tob_marker #(.EW(EW), .BW(BW)) u_mark (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_beats(in_beats), .in_exp(in_exp),
        .m_sop(m_sop), .m_eop(m_eop), .m_exp(m_exp)
    );

    generate
        if (USE_BUF) begin : g_buf
            logic [EWID-1:0] wr_ent, rd_ent;
            logic            pop;

            assign wr_ent = {m_sop, m_eop, m_exp, in_re, in_im};
            tob_fifo #(.W(EWID), .DEPTH(DEPTH), .AW(AW)) u_fifo (
                .clk(clk), .rst_n(rst_n), .push(in_valid), .din(wr_ent),
                .rd_ready(out_ready), .rd_valid(out_valid), .dout(rd_ent),
                .err(ovf_err)
            );
            assign {out_sop, out_eop, out_exp, out_re, out_im} = rd_ent;
            assign pop = out_valid && out_ready;

            // R4: exponent constant between beats of one packet
            assert_pkt_exp_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (pop && !out_eop && !ovf_err) |=> (!out_valid || out_exp == $past(out_exp)));
            // R3: the beat after an end-of-packet opens a new packet
            assert_sop_after_eop_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (pop && out_eop) |=> (!out_valid || out_sop || ovf_err));
        end else begin : g_byp
            logic unused_ready;
            assign unused_ready = out_ready;
            assign out_valid = in_valid;
            assign out_sop   = m_sop;
            assign out_eop   = m_eop;
            assign out_exp   = m_exp;
            assign out_re    = in_re;
            assign out_im    = in_im;
            assign ovf_err   = 1'b0;

            assert_byp_noerr_R9: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> !ovf_err && out_valid);
        end
    endgenerate
endmodule

// File: tb/tri_lane_outbuf_test.sv
module tri_lane_outbuf_test;
    localparam int DW = 8, EW = 8, DEPTH = 6, AW = 3, MAXB = 15;
    localparam int BW = 4, LW = 3 * DW, PW = 2 + EW + 2 * LW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, in_valid, in_start, out_ready;
    logic [BW-1:0] in_beats;
    logic [EW-1:0] in_exp;
    logic [LW-1:0] in_re, in_im;
    logic out_valid, out_sop, out_eop, ovf_err;
    logic [EW-1:0] out_exp;
    logic [LW-1:0] out_re, out_im;
    logic b_valid, b_sop, b_eop, b_err;
    logic [EW-1:0] b_exp;
    logic [LW-1:0] b_re, b_im;

    tri_lane_outbuf #(.DW(DW), .EW(EW), .DEPTH(DEPTH), .AW(AW), .MAX_BEATS(MAXB), .USE_BUF(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start), .in_beats(in_beats),
        .in_exp(in_exp), .in_re(in_re), .in_im(in_im), .out_ready(out_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_exp(out_exp),
        .out_re(out_re), .out_im(out_im), .ovf_err(ovf_err));

    tri_lane_outbuf #(.DW(DW), .EW(EW), .DEPTH(DEPTH), .AW(AW), .MAX_BEATS(MAXB), .USE_BUF(1'b0)) uut_byp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start), .in_beats(in_beats),
        .in_exp(in_exp), .in_re(in_re), .in_im(in_im), .out_ready(out_ready),
        .out_valid(b_valid), .out_sop(b_sop), .out_eop(b_eop), .out_exp(b_exp),
        .out_re(b_re), .out_im(b_im), .ovf_err(b_err));

    int total = 0, bad = 0, cyc = 0, occ = 0, rmode = 0;
    bit allow_drop = 0;
    logic [PW-1:0] expq[$];
    logic prev_valid = 0, prev_ready = 0;
    logic [PW-1:0] prev_out = '0;

    function automatic logic [DW-1:0] smp(int b, int k, int j);
        return DW'(b * 37 + k * 11 + j * 3 + 1);
    endfunction
    function automatic logic [LW-1:0] lre(int b, int j);
        logic [LW-1:0] r;
        for (int k = 0; k < 3; k++) r[k*DW +: DW] = smp(b, k, j);
        return r;
    endfunction
    function automatic logic [LW-1:0] lim(int b, int j);
        logic [LW-1:0] r;
        for (int k = 0; k < 3; k++) r[k*DW +: DW] = smp(b, k, j) ^ 8'h5A;
        return r;
    endfunction
    function automatic logic [EW-1:0] bexp(int b);
        return EW'(b * 5 + 2);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    task automatic step(input bit want, input int b, input int j, input int n, output bit taken);
        bit rdy, room, drive, pop, sp, ep;
        logic [PW-1:0] got, ent;
        @(negedge clk);
        cyc++;
        case (rmode)
            0: rdy = 1'b1;
            1: rdy = cyc[0];
            2: rdy = 1'b0;
            default: rdy = (cyc % 3) != 0;
        endcase
        room  = (occ < DEPTH) || (occ > 0 && rdy);
        drive = want && (room || allow_drop);
        sp = (j == 0);
        ep = (j == n - 1);
        out_ready = rdy;
        in_valid  = drive;
        in_start  = drive && sp;
        in_beats  = BW'(n);
        in_exp    = sp ? bexp(b) : 8'hEE;   // R4: junk on non-start beats
        in_re     = lre(b, j);
        in_im     = lim(b, j);
        ent = {sp, ep, bexp(b), lre(b, j), lim(b, j)};
        #1;
        got = {out_sop, out_eop, out_exp, out_re, out_im};
        check("R6 valid vs occupancy", 64'(out_valid), 64'(occ > 0));
        if (prev_valid && !prev_ready) check("R5 hold while stalled", 64'(got), 64'(prev_out));
        if (out_valid && expq.size() > 0) check("R2 R3 R4 head beat", 64'(got), 64'(expq[0]));
        pop = out_valid && rdy;
        if (pop && expq.size() > 0) void'(expq.pop_front());
        check("R9 bypass valid", 64'(b_valid), 64'(drive));
        check("R9 bypass err", 64'(b_err), 64'(0));
        if (drive)
            check("R9 bypass beat", 64'({b_sop, b_eop, b_exp, b_re, b_im}), 64'(ent));
        if (drive && room) expq.push_back(ent);
        occ = occ + ((drive && room) ? 1 : 0) - (pop ? 1 : 0);
        prev_valid = out_valid;
        prev_ready = rdy;
        prev_out   = got;
        taken = drive;
    endtask

    task automatic send_block(input int b, input int n);
        bit t;
        for (int j = 0; j < n; ) begin
            step(1'b1, b, j, n, t);
            if (t) j++;
        end
    endtask

    task automatic idle(input int c);
        bit t;
        for (int i = 0; i < c; i++) step(1'b0, 0, 1, 2, t);
    endtask

    task automatic drain;
        int sv;
        sv = rmode;
        rmode = 0;
        while (occ > 0) idle(1);
        idle(2);
        rmode = sv;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R0 watchdog act=%0d exp=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit t;
        rst_n = 0; in_valid = 0; in_start = 0; in_beats = '0; in_exp = '0;
        in_re = '0; in_im = '0; out_ready = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset valid", 64'(out_valid), 64'(0));
        check("R1 reset err", 64'(ovf_err), 64'(0));
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 post-reset valid", 64'(out_valid), 64'(0));

        rmode = 0;                          // R2 R3: ready always high
        send_block(0, 1); send_block(1, 2); send_block(2, 3); send_block(3, 5);
        drain();
        rmode = 1;                          // R5: alternating ready
        send_block(4, 4); send_block(5, 1);
        drain();
        rmode = 3;                          // R5 R6: three-cycle pattern, block longer than depth
        send_block(6, 6); send_block(7, 2); send_block(8, 7);
        drain();
        rmode = 2;                          // R4: parked blocks keep their own exponent
        send_block(9, 2); send_block(10, 3);
        idle(3);
        drain();
        rmode = 2;                          // R8: fill, then write while a beat leaves
        send_block(11, 6);
        rmode = 0;
        send_block(12, 2);
        check("R8 no error on full with pop", 64'(ovf_err), 64'(0));
        drain();
        rmode = 0;                          // R3: beats with idle gaps
        for (int j = 0; j < 3; j++) begin
            step(1'b1, 13, j, 3, t);
            idle(2);
        end
        drain();
        rmode = 2;                          // R7: overflow drops the excess beats
        allow_drop = 1;
        send_block(14, 8);
        allow_drop = 0;
        idle(1);
        check("R7 error set", 64'(ovf_err), 64'(1));
        check("R7 occupancy kept", 64'(occ), 64'(DEPTH));
        drain();
        check("R7 error sticky", 64'(ovf_err), 64'(1));
        send_block(15, 2);
        drain();
        check("R7 still sticky", 64'(ovf_err), 64'(1));
        check("R2 all beats seen", 64'(expq.size()), 64'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule